// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This block gathers interrupt requests from six peripheral sources and one watchdog source. It keeps a pending flag for each source and drives a single active-low interrupt line to the host. Software sees the sources through one byte-wide register address. A read returns the status byte, and a write loads the mask byte.

Each mask bit acts on one source class in one of three ways:

- **Arbiter source.** When masked, it disappears from the status byte but stays latched, and it comes back when the bit is cleared.
- **Other five peripheral sources.** When masked, they remain visible in the status byte but cannot pull the interrupt line.
- **Watchdog.** It has no mask bit and always reaches the line.

A mask write made while the line is asserted releases the line for a fixed two cycles. After that the line reflects the new mask.

Peripheral pending flags clear only through their own acknowledge inputs. The watchdog flag clears when the status byte is read.

Top module: `irq_status_mask`

## Requirements
- R1: After reset the mask is all zero (every source enabled), `reg_rdata` reads 0x00 and `irq_n` is 1.
- R2: A write sets mask bits 6..1 from `reg_wdata[6:1]`. Mask bit k+1 governs source `src_req[k]`: k=0 channel A, k=1 channel A extended, k=2 channel B, k=3 channel B extended, k=4 event controller, k=5 arbiter. A mask value of 1 disables and 0 enables. `reg_wdata[7]` and `reg_wdata[0]` have no effect.
- R3: A one-cycle pulse on `src_req[k]` sets its pending flag, shown as `reg_rdata[k+1]` from the next cycle. The flag holds until `src_ack[k]` is high. A status read (`reg_rd`) does not clear it.
- R4: When `src_req[k]` and `src_ack[k]` are high in the same cycle, the flag is pending afterwards.
- R5: While mask bit 6 is set, a pending arbiter request reads as 0 in `reg_rdata[6]` and does not assert `irq_n`. It stays latched and shows again once the bit is cleared.
- R6: For k=0..4, a set mask bit leaves the pending flag visible in `reg_rdata[k+1]`, but that source cannot assert `irq_n`.
- R7: A `wdog_req` pulse sets `reg_rdata[7]`. This flag asserts `irq_n` regardless of the mask. It is cleared by a `reg_rd` cycle unless a new `wdog_req` arrives in that same cycle.
- R8: A write made while `irq_n` is 0 holds `irq_n` at 1 for exactly the 2 cycles after the write edge. `irq_n` then reflects the new mask and the pending flags. A write made while `irq_n` is 1 starts no release.
- R9: Outside a release, `irq_n` is 0 exactly when an enabled peripheral flag or the watchdog flag is pending.
- R10: `reg_rdata[0]` always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 6 | Peripheral request pulses or levels |
| src_ack | input | 6 | Per-source acknowledge, clears pending flag |
| wdog_req | input | 1 | Watchdog request |
| reg_wr | input | 1 | Single-cycle mask write strobe |
| reg_rd | input | 1 | Status read strobe, clears watchdog flag |
| reg_wdata | input | 8 | Mask write data |
| reg_rdata | output | 8 | Status byte, combinational |
| irq_n | output | 1 | Active-low interrupt line |

## Verification
The hardest case to reach is a mask write that lands while the line is already asserted. The write must come after a request has pulled the line low, and the write data must either keep or remove that source's enable. The bench first raises a request and confirms the line is low. It then issues the write and samples the line on each of the following three cycles, which separates the two-cycle release from the re-assertion that follows. The same sequence is repeated with only the watchdog pending and every mask bit set, which shows that the line comes back even though all peripherals are disabled.

// File: rtl/isu_pkg.sv
package isu_pkg;
  localparam int unsigned NUM_PERIPH = 6;
  localparam int unsigned ARB_IDX    = 5;
  localparam int unsigned REL_CYCLES = 2;
  localparam int unsigned STAT_W     = NUM_PERIPH + 2;
endpackage

// File: rtl/isu_pend_bank.sv
module isu_pend_bank #(
  parameter int unsigned N = isu_pkg::NUM_PERIPH
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic [N-1:0] ack,
  input  logic         wd_req,
  input  logic         stat_rd,
  output logic [N-1:0] pend,
  output logic         wd_pend
);

  logic [N-1:0] pend_d;
  logic [N-1:0] pend_q;
  logic         wd_d;
  logic         wd_q;

  for (genvar i = 0; i < N; i++) begin : g_cell
    always_comb begin
      pend_d[i] = pend_q[i];
      if (ack[i]) pend_d[i] = 1'b0;
      if (req[i]) pend_d[i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else        pend_q[i] <= pend_d[i];
    end

    assert_req_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req[i] |=> pend_q[i]);
    assert_hold_no_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[i] && !ack[i]) |=> pend_q[i]);
  end

  always_comb begin
    wd_d = wd_q;
    if (stat_rd) wd_d = 1'b0;
    if (wd_req)  wd_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wd_q <= 1'b0;
    else        wd_q <= wd_d;
  end

  assert_wd_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wd_req |=> wd_q);

  assign pend    = pend_q;
  assign wd_pend = wd_q;

endmodule

// File: rtl/isu_mask_ctrl.sv
module isu_mask_ctrl #(
  parameter int unsigned N          = isu_pkg::NUM_PERIPH,
  parameter int unsigned REL_CYCLES = isu_pkg::REL_CYCLES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_stb,
  input  logic [N-1:0] wr_bits,
  input  logic         line_active,
  output logic [N-1:0] mask,
  output logic         rel_active
);

  localparam int unsigned REL_W = $clog2(REL_CYCLES + 1);

  logic [N-1:0]     mask_d;
  logic [N-1:0]     mask_q;
  logic [REL_W-1:0] rel_d;
  logic [REL_W-1:0] rel_q;
  logic             mask_en;

  assign mask_en = wr_stb;

  always_comb begin
    mask_d = mask_q;
    if (mask_en) mask_d = wr_bits;
  end

  always_comb begin
    rel_d = rel_q;
    if (rel_q != '0) rel_d = rel_q - 1'b1;
    if (wr_stb && line_active) rel_d = REL_W'(REL_CYCLES);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      rel_q  <= '0;
    end else begin
      mask_q <= mask_d;
      rel_q  <= rel_d;
    end
  end

  assign mask       = mask_q;
  assign rel_active = (rel_q != '0);

  assert_mask_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> (mask_q == $past(wr_bits)));
  assert_mask_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(mask_q));

endmodule

// File: rtl/irq_status_mask.sv
module irq_status_mask
  import isu_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PERIPH-1:0] src_req,
  input  logic [NUM_PERIPH-1:0] src_ack,
  input  logic                  wdog_req,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [STAT_W-1:0]     reg_wdata,
  output logic [STAT_W-1:0]     reg_rdata,
  output logic                  irq_n
);

  localparam logic [NUM_PERIPH-1:0] HIDE_SEL = NUM_PERIPH'(1) << ARB_IDX;

  logic [NUM_PERIPH-1:0] pend;
  logic                  wd_pend;
  logic [NUM_PERIPH-1:0] mask;
  logic                  rel_active;
  logic                  raw_req;
  logic                  line_active;
  logic                  unused_wbits;

  assign unused_wbits = reg_wdata[STAT_W-1] ^ reg_wdata[0];

  isu_pend_bank #(.N(NUM_PERIPH)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (src_req),
    .ack     (src_ack),
    .wd_req  (wdog_req),
    .stat_rd (reg_rd),
    .pend    (pend),
    .wd_pend (wd_pend)
  );

  isu_mask_ctrl #(.N(NUM_PERIPH), .REL_CYCLES(REL_CYCLES)) u_mask (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_stb      (reg_wr),
    .wr_bits     (reg_wdata[NUM_PERIPH:1]),
    .line_active (line_active),
    .mask        (mask),
    .rel_active  (rel_active)
  );

  assign raw_req     = (|(pend & ~mask)) | wd_pend;
  assign line_active = raw_req && !rel_active;
  assign irq_n       = !line_active;
  assign reg_rdata   = {wd_pend, pend & ~(mask & HIDE_SEL), 1'b0};

  assert_wd_unmaskable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_pend && !rel_active) |-> !irq_n);
  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !irq_n) |=> irq_n);
  assert_arb_hidden_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mask[ARB_IDX] |-> !reg_rdata[ARB_IDX+1]);
  assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wd_pend && ((pend & ~mask) == '0)) |-> irq_n);

endmodule

// File: tb/irq_status_mask_tb_top.sv
module irq_status_mask_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] src_req = '0;
  logic [5:0] src_ack = '0;
  logic       wdog_req = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_n;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  irq_status_mask dut_i (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_ack(src_ack),
    .wdog_req(wdog_req), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  // {req[5:0], ack[5:0], wd, wr, rd, wdata[7:0], exp_rdata[7:0], exp_irq_n}
  localparam int NV = 18;
  localparam logic [31:0] VEC [NV] = '{
    {6'b000001, 6'b000000, 3'b000, 8'h00, 8'h02, 1'b0},
    {6'b000000, 6'b000000, 3'b000, 8'h00, 8'h02, 1'b0},
    {6'b000000, 6'b000000, 3'b001, 8'h00, 8'h02, 1'b0},
    {6'b000000, 6'b000001, 3'b000, 8'h00, 8'h00, 1'b1},
    {6'b000010, 6'b000000, 3'b000, 8'h00, 8'h04, 1'b0},
    {6'b000010, 6'b000010, 3'b000, 8'h00, 8'h04, 1'b0},
    {6'b000000, 6'b000010, 3'b000, 8'h00, 8'h00, 1'b1},
    {6'b000000, 6'b000000, 3'b010, 8'hA9, 8'h00, 1'b1},
    {6'b010100, 6'b000000, 3'b000, 8'h00, 8'h28, 1'b1},
    {6'b000000, 6'b000000, 3'b100, 8'h00, 8'hA8, 1'b0},
    {6'b000000, 6'b000000, 3'b001, 8'h00, 8'h28, 1'b1},
    {6'b000000, 6'b000000, 3'b010, 8'h00, 8'h28, 1'b0},
    {6'b000000, 6'b010100, 3'b000, 8'h00, 8'h00, 1'b1},
    {6'b000000, 6'b000000, 3'b010, 8'h40, 8'h00, 1'b1},
    {6'b100000, 6'b000000, 3'b000, 8'h00, 8'h00, 1'b1},
    {6'b000000, 6'b000000, 3'b000, 8'h00, 8'h00, 1'b1},
    {6'b000000, 6'b000000, 3'b010, 8'h00, 8'h40, 1'b0},
    {6'b000000, 6'b100000, 3'b000, 8'h00, 8'h00, 1'b1}
  };

  function automatic string vec_tag(int i);
    case (i)
      0, 1: return "R3";
      2:    return "R3 read keeps flag";
      3:    return "R3 ack clears";
      4, 5: return "R4";
      6:    return "R4 ack clears";
      7:    return "R2 mask write";
      8:    return "R6";
      9:    return "R7 unmaskable";
      10:   return "R7 read clears";
      11:   return "R8 no release when idle";
      12:   return "R9";
      13, 14, 15: return "R5 hidden";
      16:   return "R5 reappears";
      default: return "R9";
    endcase
  endfunction

  task automatic chk_rd(logic [7:0] exp, string tag);
    n_chk++;
    if (reg_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s reg_rdata actual=%02h expected=%02h", tag, reg_rdata, exp);
    end
  endtask

  task automatic chk_irq(logic exp, string tag);
    n_chk++;
    if (irq_n !== exp) begin
      n_bad++;
      $display("FAIL %s irq_n actual=%0b expected=%0b", tag, irq_n, exp);
    end
  endtask

  task automatic step(logic [5:0] rq, logic [5:0] ak, logic wd, logic wr,
                      logic rd, logic [7:0] wdat);
    src_req = rq; src_ack = ak; wdog_req = wd;
    reg_wr = wr; reg_rd = rd; reg_wdata = wdat;
    @(negedge clk);
    src_req = '0; src_ack = '0; wdog_req = 1'b0;
    reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
  endtask

  task automatic idle();
    step(6'b0, 6'b0, 1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic run_all();
    @(negedge clk);
    chk_rd(8'h00, "R1 reset");
    chk_irq(1'b1, "R1 reset");
    chk_rd(8'h00, "R10 bit0");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_rd(8'h00, "R1 after release");
    chk_irq(1'b1, "R1 after release");

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      v = VEC[i];
      step(v[31:26], v[25:20], v[19], v[18], v[17], v[16:9]);
      chk_rd(v[8:1], vec_tag(i));
      chk_irq(v[0], vec_tag(i));
    end

    // R8: write while asserted, source kept enabled
    step(6'b000001, 6'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    chk_irq(1'b0, "R9 chan A asserts");
    step(6'b0, 6'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    chk_irq(1'b1, "R8 release cycle 1");
    idle();
    chk_irq(1'b1, "R8 release cycle 2");
    idle();
    chk_irq(1'b0, "R8 reassert");
    // R8 + R6: write masks the asserting source
    step(6'b0, 6'b0, 1'b0, 1'b1, 1'b0, 8'h02);
    chk_irq(1'b1, "R8 release masked 1");
    idle();
    chk_irq(1'b1, "R8 release masked 2");
    idle();
    chk_irq(1'b1, "R6 masked stays quiet");
    chk_rd(8'h02, "R6 masked visible");
    step(6'b0, 6'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    chk_irq(1'b0, "R8 idle write no release");
    step(6'b0, 6'b000001, 1'b0, 1'b0, 1'b0, 8'h00);
    chk_irq(1'b1, "R3 ack");

    // R7: request coincides with read, then all masked
    step(6'b0, 6'b0, 1'b1, 1'b0, 1'b1, 8'h00);
    chk_rd(8'h80, "R7 req beats read");
    chk_irq(1'b0, "R7 asserts");
    step(6'b0, 6'b0, 1'b0, 1'b1, 1'b0, 8'hFF);
    chk_irq(1'b1, "R8 release wd 1");
    idle();
    chk_irq(1'b1, "R8 release wd 2");
    idle();
    chk_irq(1'b0, "R7 unmaskable");
    chk_rd(8'h80, "R10 bit0 after FF write");
    step(6'b0, 6'b0, 1'b0, 1'b0, 1'b1, 8'h00);
    chk_rd(8'h00, "R7 read clears");
    chk_irq(1'b1, "R7 read clears");

    // R5: arbiter acked while hidden never appears
    step(6'b100000, 6'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    chk_rd(8'h00, "R5 hidden under full mask");
    step(6'b0, 6'b100000, 1'b0, 1'b0, 1'b0, 8'h00);
    step(6'b0, 6'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    chk_rd(8'h00, "R5 acked while hidden");
    chk_irq(1'b1, "R5 acked while hidden");
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog timeout actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule